// File: doc/BRIEF.md
# FIFO Threshold Interrupt Unit

This block gathers the interrupt conditions of a FIFO-based serial controller into one status vector and drives a single level-sensitive interrupt line. Three status bits are sticky events (transmit underflow, receive overflow, mode fault). They latch on a one-cycle pulse from the serial engine and are cleared by software writing ones to the status register. The other four bits are live comparisons. They are taken straight from the FIFO occupancy counts, the full flags and two programmable thresholds, and are never stored.

Software cannot write the mask directly. It sets mask bits by writing ones to an enable register and clears them by writing ones to a disable register. The interrupt line is high while any masked-in status bit is high. The register port is a plain write strobe with an address, and a combinational read path on the same address.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset the sticky status bits and the mask are 0, both thresholds read 1, and irq_o is low.
- R2: Status positions are: bit 0 receive overflow, bit 1 mode fault, bit 2 transmit below threshold, bit 3 transmit full, bit 4 receive at or above threshold, bit 5 receive full, bit 6 transmit underflow. The status register reads at address 0x04.
- R3: A pulse on a sticky event input sets its bit on the next clock edge. The bit stays set until a write to 0x04 with a 1 in that position. Writing ones to the live positions (bits 2 to 5) has no effect on them.
- R4: If a sticky event and a clear of that same bit fall in one cycle, the bit remains set.
- R5: Status bit 4 is 1 exactly when the receive count is greater than or equal to the receive threshold (address 0x2C).
- R6: Status bit 2 is 1 exactly when the transmit count is strictly less than the transmit threshold (address 0x28).
- R7: Status bits 5 and 3 follow the receive and transmit full flags in the same cycle.
- R8: Writing ones to 0x08 sets the matching mask bits. Writing ones to 0x0C clears them. Both addresses read as 0.
- R9: The mask reads at 0x10 as 7 bits. A write to 0x10 leaves it unchanged.
- R10: irq_o is 1 exactly when the bitwise AND of mask and status is nonzero.
- R11: Each threshold is 6 bits wide, reads back as written, and covers values 0 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address for read and write |
| wdata_i | input | 7 | Write data |
| rdata_o | output | 7 | Read data at addr_i, combinational |
| tx_count_i | input | 6 | Transmit FIFO occupancy |
| rx_count_i | input | 6 | Receive FIFO occupancy |
| tx_full_i | input | 1 | Transmit FIFO full |
| rx_full_i | input | 1 | Receive FIFO full |
| tx_underflow_i | input | 1 | Transmit underflow event pulse |
| rx_overflow_i | input | 1 | Receive overflow event pulse |
| mode_fail_i | input | 1 | Mode fault event pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can land on the same edge: the hardware setting a sticky bit and software clearing that bit by writing a one to it. The bench raises the underflow event in the same cycle that it writes 0x40 to the status register. After the edge it reads the status back and expects bit 6 still set. A later clear with no event present must then drop the bit. The bench also clears the overflow bit while the underflow event arrives, and checks that a clear aimed at one bit leaves the event on another bit intact.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned STAT_W = 7;
  localparam int unsigned ADDR_W = 8;

  localparam int unsigned B_RX_OVF  = 0;
  localparam int unsigned B_MODE    = 1;
  localparam int unsigned B_TX_LOW  = 2;
  localparam int unsigned B_TX_FULL = 3;
  localparam int unsigned B_RX_HIGH = 4;
  localparam int unsigned B_RX_FULL = 5;
  localparam int unsigned B_TX_UNF  = 6;

  localparam logic [STAT_W-1:0] STICKY_BITS = STAT_W'((1 << B_TX_UNF) | (1 << B_MODE) | (1 << B_RX_OVF));

  localparam logic [ADDR_W-1:0] A_STATUS = 8'h04;
  localparam logic [ADDR_W-1:0] A_ENABLE = 8'h08;
  localparam logic [ADDR_W-1:0] A_DISABL = 8'h0C;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h10;
  localparam logic [ADDR_W-1:0] A_TX_THR = 8'h28;
  localparam logic [ADDR_W-1:0] A_RX_THR = 8'h2C;
endpackage

// File: rtl/fifo_irq_sticky.sv
module fifo_irq_sticky #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      logic q;
      // event beats clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= (q & ~clr_i[i]) | set_i[i];
      end
      assign q_o[i] = q;

      p_event_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q_o[i]);
      p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    end else begin : g_none
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fifo_irq_mask.sv
module fifo_irq_mask #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         dis_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (en_we_i)  mask_q <= mask_q | wdata_i;
    else if (dis_we_i) mask_q <= mask_q & ~wdata_i;
  end
  assign mask_o = mask_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_we_i && wdata_i[i]) |=> mask_o[i]);
    p_disable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dis_we_i && !en_we_i && wdata_i[i]) |=> !mask_o[i]);
  end
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_we_i && !dis_we_i) |=> $stable(mask_o));
endmodule

// File: rtl/fifo_irq_level.sv
module fifo_irq_level #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_we_i,
  input  logic             rx_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             tx_full_i,
  input  logic             rx_full_i,
  output logic [CNT_W-1:0] tx_thr_o,
  output logic [CNT_W-1:0] rx_thr_o,
  output logic [W-1:0]     live_o
);
  import fifo_irq_pkg::*;

  logic [CNT_W-1:0] tx_thr_q, rx_thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= CNT_W'(1);
      rx_thr_q <= CNT_W'(1);
    end else begin
      if (tx_we_i) tx_thr_q <= wdata_i;
      if (rx_we_i) rx_thr_q <= wdata_i;
    end
  end
  assign tx_thr_o = tx_thr_q;
  assign rx_thr_o = rx_thr_q;

  always_comb begin
    live_o            = '0;
    live_o[B_RX_FULL] = rx_full_i;
    live_o[B_RX_HIGH] = (rx_count_i >= rx_thr_q);
    live_o[B_TX_FULL] = tx_full_i;
    live_o[B_TX_LOW]  = (tx_count_i < tx_thr_q);
  end

  p_tx_thr_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i |=> tx_thr_o == $past(wdata_i));
  p_rx_thr_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_we_i |=> rx_thr_o == $past(wdata_i));
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              tx_full_i,
  input  logic              rx_full_i,
  input  logic              tx_underflow_i,
  input  logic              rx_overflow_i,
  input  logic              mode_fail_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] events, clr, sticky, live, status, mask;
  logic [CNT_W-1:0]  tx_thr, rx_thr;

  always_comb begin
    events           = '0;
    events[B_TX_UNF] = tx_underflow_i;
    events[B_MODE]   = mode_fail_i;
    events[B_RX_OVF] = rx_overflow_i;
  end
  assign clr = (wr_en_i && addr_i == A_STATUS) ? (wdata_i & STICKY_BITS) : '0;

  fifo_irq_sticky #(.W(STAT_W), .KEEP(STICKY_BITS)) i_sticky (
    .clk_i, .rst_ni, .set_i(events), .clr_i(clr), .q_o(sticky)
  );

  fifo_irq_mask #(.W(STAT_W)) i_mask (
    .clk_i, .rst_ni,
    .en_we_i (wr_en_i && addr_i == A_ENABLE),
    .dis_we_i(wr_en_i && addr_i == A_DISABL),
    .wdata_i,
    .mask_o  (mask)
  );

  fifo_irq_level #(.CNT_W(CNT_W), .W(STAT_W)) i_level (
    .clk_i, .rst_ni,
    .tx_we_i   (wr_en_i && addr_i == A_TX_THR),
    .rx_we_i   (wr_en_i && addr_i == A_RX_THR),
    .wdata_i   (wdata_i[CNT_W-1:0]),
    .tx_count_i, .rx_count_i, .tx_full_i, .rx_full_i,
    .tx_thr_o  (tx_thr),
    .rx_thr_o  (rx_thr),
    .live_o    (live)
  );

  assign status = sticky | live;
  assign irq_o  = |(status & mask);

  always_comb begin
    unique case (addr_i)
      A_STATUS: rdata_o = status;
      A_MASK:   rdata_o = mask;
      A_TX_THR: rdata_o = STAT_W'(tx_thr);
      A_RX_THR: rdata_o = STAT_W'(rx_thr);
      default:  rdata_o = '0;
    endcase
  end

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
  p_live_nostore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky & ~STICKY_BITS) == '0);
endmodule

// File: tb/test_fifo_irq_unit.sv
module test_fifo_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [6:0] wdata = '0;
  logic [6:0] rdata;
  logic [5:0] tx_cnt = '0, rx_cnt = '0;
  logic       tx_full = 1'b0, rx_full = 1'b0;
  logic       ev_unf = 1'b0, ev_ovf = 1'b0, ev_mode = 1'b0;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fifo_irq_unit i_fifo_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_count_i(tx_cnt), .rx_count_i(rx_cnt),
    .tx_full_i(tx_full), .rx_full_i(rx_full), .tx_underflow_i(ev_unf),
    .rx_overflow_i(ev_ovf), .mode_fail_i(ev_mode), .irq_o(irq)
  );

  // {rx_cnt[29:24], tx_cnt[23:18], rx_full[17], tx_full[16], rx_thr[15:10], tx_thr[9:4], exp bits5..2 [3:0]}
  localparam logic [29:0] VEC [8] = '{
    {6'd0,  6'd0,  1'b0, 1'b0, 6'd1,  6'd1,  4'b0001},
    {6'd1,  6'd1,  1'b0, 1'b0, 6'd1,  6'd1,  4'b0100},
    {6'd0,  6'd5,  1'b0, 1'b0, 6'd0,  6'd0,  4'b0100},
    {6'd31, 6'd31, 1'b0, 1'b0, 6'd32, 6'd32, 4'b0001},
    {6'd32, 6'd32, 1'b1, 1'b1, 6'd32, 6'd32, 4'b1110},
    {6'd15, 6'd16, 1'b0, 1'b0, 6'd16, 6'd16, 4'b0000},
    {6'd16, 6'd15, 1'b0, 1'b0, 6'd16, 6'd16, 4'b0101},
    {6'd0,  6'd10, 1'b1, 1'b0, 6'd5,  6'd11, 4'b1001}
  };

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [6:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [6:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state (counts 0, threshold 1 -> live bit 2 only)
    #1 chk("R1 irq", {6'd0, irq}, 7'd0);
    rst_n = 1'b1;
    rd(8'h04, r); chk("R1 status", r, 7'h04);
    rd(8'h10, r); chk("R1 mask", r, 7'h00);
    rd(8'h28, r); chk("R1 tx thr", r, 7'd1);
    rd(8'h2C, r); chk("R1 rx thr", r, 7'd1);

    // R5 R6 R7 R11 table
    for (int i = 0; i < 8; i++) begin
      wr(8'h2C, {1'b0, VEC[i][15:10]});
      wr(8'h28, {1'b0, VEC[i][9:4]});
      rd(8'h2C, r); chk("R11 rx thr", r, {1'b0, VEC[i][15:10]});
      rd(8'h28, r); chk("R11 tx thr", r, {1'b0, VEC[i][9:4]});
      @(negedge clk);
      rx_cnt = VEC[i][29:24]; tx_cnt = VEC[i][23:18];
      rx_full = VEC[i][17];   tx_full = VEC[i][16];
      rd(8'h04, r); chk("R5 R6 R7 live", r, {1'b0, VEC[i][3:0], 2'b00});
    end

    // restore: live bits all 0
    wr(8'h28, 7'd1); wr(8'h2C, 7'd1);
    @(negedge clk); rx_cnt = 6'd0; tx_cnt = 6'd3; rx_full = 1'b0; tx_full = 1'b0;
    rd(8'h04, r); chk("R6 quiet", r, 7'h00);

    // R2 R3 each event to its own position
    @(negedge clk); ev_unf = 1'b1; @(negedge clk); ev_unf = 1'b0;
    rd(8'h04, r); chk("R2 R3 underflow bit6", r, 7'h40);
    @(negedge clk); ev_mode = 1'b1; @(negedge clk); ev_mode = 1'b0;
    rd(8'h04, r); chk("R2 R3 mode bit1", r, 7'h42);
    @(negedge clk); ev_ovf = 1'b1; @(negedge clk); ev_ovf = 1'b0;
    rd(8'h04, r); chk("R2 R3 overflow bit0", r, 7'h43);
    repeat (3) @(negedge clk);
    rd(8'h04, r); chk("R3 hold", r, 7'h43);
    wr(8'h04, 7'h02);
    rd(8'h04, r); chk("R3 clear bit1", r, 7'h41);
    // R4 event wins over clear; clear of another bit still works
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h04; wdata = 7'h41; ev_unf = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev_unf = 1'b0;
    rd(8'h04, r); chk("R4 event wins", r, 7'h40);
    wr(8'h04, 7'h40);
    rd(8'h04, r); chk("R3 clear bit6", r, 7'h00);
    // R3 writing ones to live bits does nothing
    @(negedge clk); tx_full = 1'b1;
    wr(8'h04, 7'h3C);
    rd(8'h04, r); chk("R3 live not cleared", r, 7'h08);
    @(negedge clk); tx_full = 1'b0;

    // R8 R9 mask
    wr(8'h08, 7'h7F);
    rd(8'h10, r); chk("R8 enable all", r, 7'h7F);
    rd(8'h08, r); chk("R8 enable reads 0", r, 7'h00);
    rd(8'h0C, r); chk("R8 disable reads 0", r, 7'h00);
    wr(8'h0C, 7'h7B);
    rd(8'h10, r); chk("R8 disable", r, 7'h04);
    wr(8'h10, 7'h00);
    rd(8'h10, r); chk("R9 mask write ignored", r, 7'h04);

    // R10 irq
    #1 chk("R10 no source", {6'd0, irq}, 7'd0);
    @(negedge clk); tx_cnt = 6'd0;
    #1 chk("R10 live bit2", {6'd0, irq}, 7'd1);
    @(negedge clk); tx_cnt = 6'd3;
    #1 chk("R10 live drop", {6'd0, irq}, 7'd0);
    @(negedge clk); ev_ovf = 1'b1; @(negedge clk); ev_ovf = 1'b0;
    #1 chk("R10 masked sticky", {6'd0, irq}, 7'd0);
    wr(8'h08, 7'h01);
    #1 chk("R10 sticky enabled", {6'd0, irq}, 7'd1);
    wr(8'h04, 7'h01);
    #1 chk("R10 cleared", {6'd0, irq}, 7'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule